// File: doc/BRIEF.md
# Bit-Serial Configurable Logic Cell

This block is one cell of a programmable fabric. It is tuned for datapaths that handle one bit per clock and for pipelining at the level of single bits. The cell holds four 4-input lookup tables arranged as two pairs. Pair zero reads operand pins `a_i[3:0]` and pair one reads `b_i[3:0]`. Each table has a selectable source for its top address bit: its own pin, a spare pin, a constant, or the stored value of any of the four logic outputs. This lets a sum or carry held in a flip-flop return to the tables on the next clock. A carry-save multiplexer per pair can replace the third address bit with an alternate operand. Output multiplexers steered by `a_i[4]` and `b_i[4]` can merge a pair into one 5-input function. Each logic output is either combinational or taken from its own flip-flop. Two further flip-flops capture the shift pins and serve as shift-register stages.

All programming arrives through a serial chain while `cfg_en` is high. The six outputs stay at zero until a complete load has finished. Six data flip-flops share a synchronous active-high reset and one clock enable. A typical use is an LSB-first serial adder: one table makes the sum, the other makes the carry, and the carry flip-flop feeds back into both tables. A "first bit" pin masks the old carry at the start of each word.

Top module: `bitserial_logic_cell`

## Requirements
- R1: The configuration is 86 bits, shifted in at `cfg_in` one per clock while `cfg_en` is high, with chain bit 0 sent first. Layout: table k in bits [16k+15:16k]; source code k in bits [64+3k+2:64+3k]; carry-save enables in [77:76]; merge enables in [81:78]; register enables in [85:82]. All six outputs read 0 until at least 86 bits have been shifted and `cfg_en` has returned low. A shorter load leaves the outputs at 0.
- R2: Each table's address is {bit3, bit2, in1, in0}, where in0 is the least significant bit. The table output is the configured bit at that address. Pair zero (tables 0,1) uses `a_i[1:0]` and pair one (tables 2,3) uses `b_i[1:0]`.
- R3: The 3-bit source code of table k sets address bit3 as follows: 0 = the pair's operand pin 3; 1 = `z_i[k]`; 2 = constant 0; 3 = constant 1; 4..7 = the stored flip-flop value of logic output 0..3.
- R4: When the carry-save enable of pair p is 1, address bit2 of both tables in the pair comes from `cs_i[p]` instead of operand pin 2.
- R5: When the merge enable of output k is 1, output k takes the pair's odd table if the pair select (`a_i[4]` for pair zero, `b_i[4]` for pair one) is 1, and the pair's even table otherwise. When the merge enable is 0, output k takes table k.
- R6: When the register enable of output k is 1, `d_o[k]` shows a flip-flop that captures the multiplexer result at each enabled clock edge. When it is 0, `d_o[k]` follows the multiplexer with no clock.
- R7: `d_o[4]` and `d_o[5]` show flip-flops that capture `sh_i[0]` and `sh_i[1]` at each enabled clock edge.
- R8: While `ce` is low, all six data flip-flops hold their values.
- R9: A high `rst` at a clock edge clears all six data flip-flops and the load state, so all outputs read 0 until the next complete load. Reset takes priority over `ce`.
- R10: Using a feedback source code 4..7 that names a logic output in direct mode is a configuration error. It is flagged in simulation. Feedback always takes the flip-flop value, so no combinational loop can form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the six data flip-flops |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Configuration serial data |
| a_i | input | 5 | Pair-zero operands [3:0], pair-zero merge select [4] |
| b_i | input | 5 | Pair-one operands [3:0], pair-one merge select [4] |
| z_i | input | 4 | Spare bit3 sources, one per table |
| cs_i | input | 2 | Carry-save alternate operand per pair |
| sh_i | input | 2 | Shift flip-flop inputs |
| d_o | output | 6 | Logic outputs [3:0], shift flip-flop outputs [5:4] |

## Verification
The assertions check the following on every cycle:
- a configuration load forces the outputs low;
- reset clears the outputs;
- the flip-flops hold while `ce` is low;
- the shift stages capture their pins;
- no enabled source code names a direct-mode output.

The table addressing, the source-code decoding, the carry-save and merge multiplexers, and the lag of registered feedback can only be shown by the bench's scenarios. The main one is a serial adder run over fixed and random operands, in which the carry loops through the feedback path.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int K      = 4;
  localparam int TBL    = 1 << K;
  localparam int NL     = 4;
  localparam int NPAIR  = NL / 2;
  localparam int FBW    = 3;
  localparam int NSH    = 2;
  localparam int NOUT   = NL + NSH;
  localparam int TBL_LO = 0;
  localparam int SRC_LO = TBL_LO + NL * TBL;
  localparam int CS_LO  = SRC_LO + NL * FBW;
  localparam int MG_LO  = CS_LO + NPAIR;
  localparam int RG_LO  = MG_LO + NL;
  localparam int CFG_LEN = RG_LO + NL;

  typedef enum logic [1:0] {
    SRC_OPER = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_ONE  = 2'd3
  } src_low_e;

  function automatic logic lut_read(input logic [TBL-1:0] t, input logic [K-1:0] adr);
    return t[adr];
  endfunction

  function automatic logic src_pick(input logic [FBW-1:0] code, input logic oper3,
                                    input logic ext, input logic [NL-1:0] q);
    logic r;
    if (code[2]) begin
      r = q[code[1:0]];
    end else begin
      case (src_low_e'(code[1:0]))
        SRC_OPER: r = oper3;
        SRC_EXT:  r = ext;
        SRC_ZERO: r = 1'b0;
        default:  r = 1'b1;
      endcase
    end
    return r;
  endfunction

  function automatic logic pair_mux(input logic merge, input logic sel,
                                    input logic own, input logic even, input logic odd);
    return merge ? (sel ? odd : even) : own;
  endfunction
endpackage

// File: rtl/slc_cfg_chain.sv
module slc_cfg_chain
  import slc_pkg::*;
#(
  parameter int LEN = CFG_LEN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_in,
  output logic [LEN-1:0] cfg_q,
  output logic           cfg_done
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] bit_cnt;
  logic          load_full;

  assign load_full = (bit_cnt == FULL);

  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q <= {cfg_in, cfg_q[LEN-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_en) begin
      bit_cnt  <= load_full ? bit_cnt : bit_cnt + CW'(1);
      cfg_done <= 1'b0;
    end else begin
      bit_cnt <= '0;
      if (load_full) cfg_done <= 1'b1;
    end
  end

  // R1
  load_blocks_done_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> !cfg_done);
endmodule

// File: rtl/slc_lut_pair.sv
module slc_lut_pair
  import slc_pkg::*;
(
  input  logic [K-1:0]             oper,
  input  logic                     pick,
  input  logic                     cs_bit,
  input  logic                     cs_on,
  input  logic [1:0]               ext,
  input  logic [NL-1:0]            q_fb,
  input  logic [1:0][TBL-1:0]      tbl,
  input  logic [1:0][FBW-1:0]      src_code,
  input  logic [1:0]               merge_on,
  output logic [1:0]               m_out
);
  logic [1:0][K-1:0] addr;
  logic [1:0]        lut_o;
  logic              bit2;

  assign bit2 = cs_on ? cs_bit : oper[K-2];

  for (genvar j = 0; j < 2; j++) begin : g_lut
    assign addr[j]  = {src_pick(src_code[j], oper[K-1], ext[j], q_fb), bit2, oper[K-3:0]};
    assign lut_o[j] = lut_read(tbl[j], addr[j]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_omux
    assign m_out[j] = pair_mux(merge_on[j], pick, lut_o[j], lut_o[0], lut_o[1]);
  end
endmodule

// File: rtl/bitserial_logic_cell.sv
module bitserial_logic_cell
  import slc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            cfg_en,
  input  logic            cfg_in,
  input  logic [K:0]      a_i,
  input  logic [K:0]      b_i,
  input  logic [NL-1:0]   z_i,
  input  logic [NPAIR-1:0] cs_i,
  input  logic [NSH-1:0]  sh_i,
  output logic [NOUT-1:0] d_o
);
  logic [CFG_LEN-1:0]         cfg_q;
  logic                       cfg_done;
  logic [NL-1:0][TBL-1:0]     tbl;
  logic [NL-1:0][FBW-1:0]     src_code;
  logic [NPAIR-1:0]           cs_on;
  logic [NL-1:0]              merge_on;
  logic [NL-1:0]              reg_on;
  logic [NL-1:0]              m_all;
  logic [NL-1:0]              lut_q;
  logic [NSH-1:0]             sh_q;
  logic [NL-1:0]              dsel;
  logic [NL-1:0]              loop_hit;
  logic                       direct_fb_hit;

  slc_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .cfg_done(cfg_done)
  );

  for (genvar k = 0; k < NL; k++) begin : g_dec
    assign tbl[k]      = cfg_q[TBL_LO + k*TBL +: TBL];
    assign src_code[k] = cfg_q[SRC_LO + k*FBW +: FBW];
    assign merge_on[k] = cfg_q[MG_LO + k];
    assign reg_on[k]   = cfg_q[RG_LO + k];
    assign loop_hit[k] = src_code[k][FBW-1] && !reg_on[src_code[k][1:0]];
  end
  assign cs_on = cfg_q[CS_LO +: NPAIR];
  assign direct_fb_hit = |loop_hit;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [K-1:0] oper;
    logic         pick;
    assign oper = (p == 0) ? a_i[K-1:0] : b_i[K-1:0];
    assign pick = (p == 0) ? a_i[K] : b_i[K];
    slc_lut_pair u_pair (
      .oper(oper), .pick(pick), .cs_bit(cs_i[p]), .cs_on(cs_on[p]),
      .ext(z_i[2*p +: 2]), .q_fb(lut_q),
      .tbl(tbl[2*p +: 2]), .src_code(src_code[2*p +: 2]),
      .merge_on(merge_on[2*p +: 2]), .m_out(m_all[2*p +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_q <= '0;
      sh_q  <= '0;
    end else if (ce) begin
      lut_q <= m_all;
      sh_q  <= sh_i;
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_osel
    assign dsel[k] = reg_on[k] ? lut_q[k] : m_all[k];
  end

  assign d_o = cfg_done ? {sh_q, dsel} : '0;

  // R10
  no_direct_feedback_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> !direct_fb_hit);
  // R9
  reset_clears_out_chk: assert property (@(posedge clk)
    rst |=> (d_o == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(lut_q) && $stable(sh_q)));
  // R7
  shift_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (sh_q == $past(sh_i)));
endmodule

// File: tb/tb_bitserial_logic_cell.sv
`timescale 1ns/1ps
module tb_bitserial_logic_cell;
  logic clk = 1'b0;
  logic rst = 1'b1, ce = 1'b1, cfg_en = 1'b0, cfg_in = 1'b0;
  logic [4:0] a_i = '0, b_i = '0;
  logic [3:0] z_i = '0;
  logic [1:0] cs_i = '0, sh_i = '0;
  logic [5:0] d_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bitserial_logic_cell dut (
    .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .a_i(a_i), .b_i(b_i), .z_i(z_i), .cs_i(cs_i), .sh_i(sh_i), .d_o(d_o)
  );

  localparam logic [24:0] VEC [8] = '{
    {8'h00, 8'h00, 9'h000}, {8'hFF, 8'h01, 9'h100},
    {8'hFF, 8'hFF, 9'h1FE}, {8'h5A, 8'hA5, 9'h0FF},
    {8'h80, 8'h80, 9'h100}, {8'h37, 8'hC9, 9'h100},
    {8'h12, 8'h34, 9'h046}, {8'h7F, 8'h01, 9'h080}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [85:0] pack_cfg(
    input logic [15:0] t0, t1, t2, t3, input logic [2:0] f0, f1, f2, f3,
    input logic [1:0] cs, input logic [3:0] mg, input logic [3:0] rg);
    logic [85:0] v;
    v = {rg, mg, cs, f3, f2, f1, f0, t3, t2, t1, t0};
    return v;
  endfunction

  function automatic logic [15:0] add_tbl(input bit want_carry);
    logic [15:0] t;
    for (int ad = 0; ad < 16; ad++) begin
      logic x, y, f, c, ci;
      x = ad[0]; y = ad[1]; f = ad[2]; c = ad[3];
      ci = c & ~f;
      t[ad] = want_carry ? ((x & y) | (x & ci) | (y & ci)) : (x ^ y ^ ci);
    end
    return t;
  endfunction

  task automatic load(input logic [85:0] v, input int nbits);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      cfg_in = v[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_add(input logic [7:0] x, input logic [7:0] y, output logic [8:0] s);
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i > 0) s[i-1] = d_o[0];
      a_i = {2'b00, (i == 0), (i < 8) ? y[i] : 1'b0, (i < 8) ? x[i] : 1'b0};
    end
    @(negedge clk);
    s[8] = d_o[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [85:0] cfg_add, cfg_b;
    logic [8:0] s;
    cfg_add = pack_cfg(add_tbl(1'b0), add_tbl(1'b1), 16'h0, 16'h0,
                       3'd5, 3'd5, 3'd2, 3'd2, 2'b00, 4'b0000, 4'b0011);
    cfg_b = pack_cfg(16'h0002, 16'hFF00, 16'hF0F0, 16'hFF00,
                     3'd0, 3'd1, 3'd2, 3'd3, 2'b10, 4'b1000, 4'b0000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    a_i = '1; b_i = '1; z_i = '1; cs_i = '1; sh_i = '1;
    @(negedge clk); @(negedge clk);
    chk("R9 reset state, outputs low", d_o, 6'h0);
    // R1: short load keeps outputs low
    load(cfg_b, 40);
    chk("R1 short load keeps outputs low", d_o, 6'h0);
    a_i = '0; b_i = '0; z_i = '0; cs_i = '0; sh_i = '0;
    // Serial adder through registered feedback (R3, R6)
    load(cfg_add, 86);
    foreach (VEC[i]) begin
      run_add(VEC[i][24:17], VEC[i][16:9], s);
      chk("R3/R6 serial add table vector", s, VEC[i][8:0]);
    end
    for (int r = 0; r < 12; r++) begin
      logic [7:0] x, y;
      x = 8'($urandom); y = 8'($urandom);
      run_add(x, y, s);
      chk("R3/R6 serial add random", s, {1'b0, x} + {1'b0, y});
    end
    // R6 registered output lags by one edge
    @(negedge clk); a_i = 5'b00101;
    #1 chk("R6 registered output before edge", d_o[0], 1'b0);
    @(negedge clk);
    chk("R6 registered output after edge", d_o[0], 1'b1);
    // Directed configuration
    load(cfg_b, 86);
    a_i = 5'b00001; #1 chk("R2 address 1 selects bit 1", d_o[0], 1'b1);
    a_i = 5'b00010; #1 chk("R2 address 2 selects bit 2", d_o[0], 1'b0);
    a_i = 5'b01001; #1 chk("R2 address 9 selects bit 9", d_o[0], 1'b0);
    z_i = 4'b0010; #1 chk("R3 source 1 spare pin high", d_o[1], 1'b1);
    z_i = 4'b0000; a_i = 5'b01000; #1 chk("R3 source 1 ignores operand 3", d_o[1], 1'b0);
    cs_i = 2'b10; b_i = 5'b00000; #1 chk("R4 carry-save pin selected", d_o[2], 1'b1);
    cs_i = 2'b00; b_i = 5'b00100; #1 chk("R4 operand 2 bypassed", d_o[2], 1'b0);
    b_i = 5'b10000; #1 chk("R5 merge select high picks odd table", d_o[3], 1'b1);
    b_i = 5'b00000; cs_i = 2'b10; #1 chk("R5 merge select low picks even table", d_o[3], 1'b1);
    cs_i = 2'b00; #1 chk("R5 merge even table low", d_o[3], 1'b0);
    // R7 shift stages
    @(negedge clk); sh_i = 2'b01;
    @(negedge clk);
    chk("R7 shift stages capture", d_o[5:4], 2'b01);
    // R8 hold while ce low
    ce = 1'b0; sh_i = 2'b10;
    @(negedge clk); @(negedge clk);
    chk("R8 shift stages hold with ce low", d_o[5:4], 2'b01);
    // R9 reset clears flops over ce, and clears the load
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9 outputs low after reset", d_o, 6'h0);
    sh_i = 2'b11;
    load(cfg_b, 86);
    chk("R9 shift flops cleared by reset", d_o[5:4], 2'b00);
    ce = 1'b1;
    finish_run();
  end
endmodule